// File: doc/BRIEF.md
# Audio Serial Master Transmitter

This block drives a stereo audio link as its master. It derives the bit clock from the system clock with a programmable divider, and it produces the channel-select or frame-sync line. It shifts left and right samples onto one serial data pin, most significant bit first. It can also drive a master clock pin.

Static configuration inputs set the following:
- the framing standard: Philips-style I2S, MSB-justified, LSB-justified, or PCM with short or long sync;
- the sample length and the slot (channel) length;
- the bit-clock edge on which outputs launch;
- an inversion of the channel-select phase;
- whether input words are right- or left-aligned on the bus.

The configuration is meant to be changed only while reset is held. Samples enter through a valid/ready handshake with a right/left tag. One sample per channel can wait ahead of the shifter. A channel whose slot starts with no waiting sample is sent as zeros.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is held, `bclk_o`, `ws_o`, `sd_o` and `mclk_o` are low and `s_ready_o` is high.
- R2: One bit period lasts N system clocks, with N = 2*P + `cfg_odd_i` and P = `cfg_div_i` raised to 2 when it is below 2. Counting system edges after reset release as e = 1, 2, ..., the raw bit-clock level after edge e is 1 when (e mod N) >= floor(N/2), else 0. Each bit period begins at an edge where e mod N = 0.
- R3: `bclk_o` is the raw level XOR `cfg_pol_i`. `sd_o` and `ws_o` change only at the start of a bit period, which is the edge that takes `bclk_o` to the level `cfg_pol_i`.
- R4: Standards code 0 (Philips), 1 (MSB-justified) and 2 (LSB-justified) share the same channel-select rule. A frame has 2*C bit slots, and position p counts from 0 in the first bit period after reset. `ws_o` is (p >= C) XOR `cfg_wsinv_i`. Slots below C belong to the left channel.
- R5: In code 0, each channel's first data bit goes out at a data offset of 1. The left channel's first bit follows the `ws_o` edge into the left half by one bit slot, and the right channel's first bit follows the edge into the right half by one slot. The last bit of a right word can spill into slot 0 of the next frame.
- R6: In code 1, a channel's first data bit shares its slot with the `ws_o` edge (offset 0). In code 2, the offset is C - D, so the last data bit lands in the channel's last slot.
- R7: Code 3 is PCM. With `cfg_pcm_long_i` = 0, `ws_o` is high only at p = 0 and data starts at offset 1. With `cfg_pcm_long_i` = 1, `ws_o` is high for p = 0..12 and data starts at offset 0. The left word comes first, then the right word.
- R8: The data length D is 16, 24 or 32 for `cfg_dlen_i` = 0, 1, 2. Code 3 means 32. The slot length C is 32 when `cfg_chlen_i` = 1 or D > 16, otherwise 16. Slots of a channel beyond its D data bits carry 0.
- R9: With `cfg_left_align_i` = 0, the sample occupies `s_data_i[D-1:0]`. With `cfg_left_align_i` = 1, it occupies `s_data_i[31:32-D]`. Other bus bits are ignored.
- R10: For the channel tagged by `s_right_i` (1 = right), `s_ready_o` is high exactly when that channel holds no waiting sample. A channel whose first data slot starts while it holds no waiting sample sends zeros for that word.
- R11: With `cfg_mclk_en_i` = 1, `mclk_o` toggles on every system clock edge. With `cfg_mclk_en_i` = 0, it is low one edge later and stays low.
- R12: Data bits are sent from the most significant bit of the aligned sample down to the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_std_i | input | 2 | Framing standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| cfg_pcm_long_i | input | 1 | PCM sync style: 0 short, 1 long |
| cfg_dlen_i | input | 2 | Data length code: 0 16-bit, 1 24-bit, 2 32-bit |
| cfg_chlen_i | input | 1 | Slot length: 0 16-bit, 1 32-bit |
| cfg_pol_i | input | 1 | Bit-clock polarity |
| cfg_wsinv_i | input | 1 | Inverts channel-select phase in non-PCM standards |
| cfg_left_align_i | input | 1 | Sample alignment on the input bus: 0 right, 1 left |
| cfg_div_i | input | DIV_W | Linear prescaler P |
| cfg_odd_i | input | 1 | Adds one to the divide ratio |
| cfg_mclk_en_i | input | 1 | Master clock output enable |
| s_valid_i | input | 1 | Sample valid |
| s_ready_o | output | 1 | Sample accepted when high with valid |
| s_right_i | input | 1 | Channel tag: 0 left, 1 right |
| s_data_i | input | 32 | Sample word |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Channel select or frame sync |
| sd_o | output | 1 | Serial data |
| mclk_o | output | 1 | Master clock |

## Verification
Several properties are checked on every cycle:
- `bclk_o` always sits at the polarity level right after a bit-period start;
- `sd_o` and `ws_o` only change at a bit-period start;
- an accepted sample always leaves its channel slot occupied;
- `mclk_o` goes quiet once disabled;
- the frame position stays inside the frame.

The per-standard placement of data bits needs the bench's cycle-by-cycle model and its scenarios to show. These cover the Philips delay, the justified offsets, the PCM sync widths, zero padding, alignment, length forcing and the zero words sent on underrun.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'd0,
        STD_MSB     = 2'd1,
        STD_LSB     = 2'd2,
        STD_PCM     = 2'd3
    } aud_std_e;

endpackage

// File: rtl/aud_clkdiv.sv
module aud_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             pol_i,
    input  logic             mclk_en_i,
    output logic             tick_o,
    output logic             bclk_o,
    output logic             mclk_o
);

    localparam int unsigned CNT_W = DIV_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
        logic             mclk;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;

    always_comb begin
        div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        ratio   = {1'b0, div_eff, odd_i};
        half    = ratio >> 1;
        tick_o  = (st_q.cnt >= (ratio - CNT_W'(1)));

        st_d      = st_q;
        st_d.cnt  = tick_o ? '0 : st_q.cnt + CNT_W'(1);
        st_d.bclk = (st_d.cnt >= half) ^ pol_i;
        st_d.mclk = mclk_en_i & ~st_q.mclk;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;
    assign mclk_o = st_q.mclk;

    assert_bclk_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (bclk_o == $past(pol_i)));

    assert_mclk_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mclk_en_i |=> !mclk_o);

    assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(div_i) && $stable(odd_i) |-> (st_q.cnt < ratio));

endmodule

// File: rtl/aud_sample_buf.sv
module aud_sample_buf
    import aud_tx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        dlen_i,
    input  logic              left_align_i,
    input  logic              valid_i,
    input  logic              right_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              ready_o,
    input  logic              load_i,
    input  logic              load_ch_i,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [1:0][WORD_W-1:0] slot;
        logic [1:0]             full;
    } buf_state_t;

    buf_state_t st_d, st_q;

    logic [5:0]        pad;
    logic [WORD_W-1:0] norm;
    logic              accept;

    always_comb begin
        unique case (dlen_i)
            2'd0:    pad = 6'd16;
            2'd1:    pad = 6'd8;
            default: pad = 6'd0;
        endcase
        norm = left_align_i ? (data_i & ({WORD_W{1'b1}} << pad)) : (data_i << pad);

        ready_o = ~st_q.full[right_i];
        accept  = valid_i & ready_o;
        word_o  = st_q.full[load_ch_i] ? st_q.slot[load_ch_i] : '0;

        st_d = st_q;
        if (load_i) begin
            st_d.full[load_ch_i] = 1'b0;
        end
        if (accept) begin
            st_d.slot[right_i] = norm;
            st_d.full[right_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_left_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o && !right_i) |=> st_q.full[0]);

    assert_right_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o && right_i) |=> st_q.full[1]);

endmodule

// File: rtl/aud_framer.sv
module aud_framer
    import aud_tx_pkg::*;
#(
    parameter int unsigned PCM_LONG_LEN = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [1:0]        std_i,
    input  logic              pcm_long_i,
    input  logic [1:0]        dlen_i,
    input  logic              chlen_i,
    input  logic              wsinv_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              load_o,
    output logic              load_ch_o,
    output logic              sd_o,
    output logic              ws_o
);

    localparam int unsigned POS_W = 7;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic              started;
        logic [WORD_W-1:0] sh;
        logic              sd;
        logic              ws;
    } frm_state_t;

    frm_state_t st_d, st_q;

    aud_std_e         std_sel;
    logic             cl32;
    logic             ch;
    logic [POS_W-1:0] cl, dl, frame_len, off, pos_inc, pn, rel, k;

    always_comb begin
        std_sel   = aud_std_e'(std_i);
        cl32      = chlen_i | (dlen_i != 2'd0);
        cl        = cl32 ? POS_W'(32) : POS_W'(16);
        unique case (dlen_i)
            2'd0:    dl = POS_W'(16);
            2'd1:    dl = POS_W'(24);
            default: dl = POS_W'(32);
        endcase
        frame_len = cl << 1;

        unique case (std_sel)
            STD_PHILIPS: off = POS_W'(1);
            STD_MSB:     off = POS_W'(0);
            STD_LSB:     off = cl - dl;
            default:     off = pcm_long_i ? POS_W'(0) : POS_W'(1);
        endcase

        pos_inc   = st_q.pos + POS_W'(1);
        pn        = !st_q.started ? '0 : ((pos_inc >= frame_len) ? '0 : pos_inc);
        rel       = (pn >= off) ? (pn - off) : (pn + frame_len - off);
        ch        = (rel >= cl);
        k         = ch ? (rel - cl) : rel;
        load_o    = tick_i && (k == '0);
        load_ch_o = ch;

        st_d = st_q;
        if (tick_i) begin
            st_d.started = 1'b1;
            st_d.pos     = pn;
            st_d.sh      = (k == '0) ? word_i : {st_q.sh[WORD_W-2:0], 1'b0};
            st_d.sd      = (k < dl) ? st_d.sh[WORD_W-1] : 1'b0;
            if (std_sel == STD_PCM) begin
                st_d.ws = pcm_long_i ? (pn < POS_W'(PCM_LONG_LEN)) : (pn == '0);
            end else begin
                st_d.ws = (pn >= cl) ^ wsinv_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_o = st_q.sd;
    assign ws_o = st_q.ws;

    assert_sd_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sd_o) |-> $past(tick_i));

    assert_ws_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ws_o) |-> $past(tick_i));

    assert_pos_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(chlen_i) && $stable(dlen_i) |-> (st_q.pos < frame_len));

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned PCM_LONG_LEN = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        cfg_std_i,
    input  logic              cfg_pcm_long_i,
    input  logic [1:0]        cfg_dlen_i,
    input  logic              cfg_chlen_i,
    input  logic              cfg_pol_i,
    input  logic              cfg_wsinv_i,
    input  logic              cfg_left_align_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              cfg_odd_i,
    input  logic              cfg_mclk_en_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic              s_right_i,
    input  logic [WORD_W-1:0] s_data_i,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic              mclk_o
);

    logic              tick;
    logic              load;
    logic              load_ch;
    logic [WORD_W-1:0] word;

    aud_clkdiv #(
        .DIV_W(DIV_W)
    ) i_clkdiv (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (cfg_div_i),
        .odd_i     (cfg_odd_i),
        .pol_i     (cfg_pol_i),
        .mclk_en_i (cfg_mclk_en_i),
        .tick_o    (tick),
        .bclk_o    (bclk_o),
        .mclk_o    (mclk_o)
    );

    aud_sample_buf i_sample_buf (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .dlen_i       (cfg_dlen_i),
        .left_align_i (cfg_left_align_i),
        .valid_i      (s_valid_i),
        .right_i      (s_right_i),
        .data_i       (s_data_i),
        .ready_o      (s_ready_o),
        .load_i       (load),
        .load_ch_i    (load_ch),
        .word_o       (word)
    );

    aud_framer #(
        .PCM_LONG_LEN(PCM_LONG_LEN)
    ) i_framer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .std_i      (cfg_std_i),
        .pcm_long_i (cfg_pcm_long_i),
        .dlen_i     (cfg_dlen_i),
        .chlen_i    (cfg_chlen_i),
        .wsinv_i    (cfg_wsinv_i),
        .word_i     (word),
        .load_o     (load),
        .load_ch_o  (load_ch),
        .sd_o       (sd_o),
        .ws_o       (ws_o)
    );

endmodule

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_std = 2'd0;
    logic        cfg_pcm_long = 1'b0;
    logic [1:0]  cfg_dlen = 2'd0;
    logic        cfg_chlen = 1'b0;
    logic        cfg_pol = 1'b0;
    logic        cfg_wsinv = 1'b0;
    logic        cfg_left_align = 1'b0;
    logic [7:0]  cfg_div = 8'd2;
    logic        cfg_odd = 1'b0;
    logic        cfg_mclk_en = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_right = 1'b0;
    logic [31:0] s_data = 32'd0;
    logic        s_ready, bclk, ws, sd, mclk;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // reference model state
    int        e;
    bit [31:0] m_slot [2];
    bit        m_full [2];
    bit [31:0] m_cur;
    bit        m_sd, m_ws, m_bclk, m_mclk, m_acc;
    bit [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    audio_ser_tx i_audio_ser_tx (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_std_i(cfg_std), .cfg_pcm_long_i(cfg_pcm_long), .cfg_dlen_i(cfg_dlen),
        .cfg_chlen_i(cfg_chlen), .cfg_pol_i(cfg_pol), .cfg_wsinv_i(cfg_wsinv),
        .cfg_left_align_i(cfg_left_align), .cfg_div_i(cfg_div), .cfg_odd_i(cfg_odd),
        .cfg_mclk_en_i(cfg_mclk_en),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_right_i(s_right), .s_data_i(s_data),
        .bclk_o(bclk), .ws_o(ws), .sd_o(sd), .mclk_o(mclk)
    );

    function automatic int data_len();
        return (cfg_dlen == 2'd0) ? 16 : (cfg_dlen == 2'd1) ? 24 : 32;
    endfunction

    function automatic int slot_len();
        return (cfg_chlen || data_len() > 16) ? 32 : 16;
    endfunction

    // R9: place the sample at the top of a 32-bit word
    function automatic bit [31:0] aligned(input bit [31:0] d);
        int pad;
        pad = 32 - data_len();
        if (cfg_left_align) return d & (32'hFFFF_FFFF << pad);
        return d << pad;
    endfunction

    task automatic check(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %0b exp %0b at %0t", what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int n, h, cl, dl, off, pn, rel, ch, k;
        bit tag;
        if (!rst_n) begin
            e = 0; m_full[0] = 0; m_full[1] = 0; m_cur = 0;
            m_sd = 0; m_ws = 0; m_bclk = 0; m_mclk = 0; m_acc = 0;
        end else begin
            n   = 2 * ((cfg_div < 2) ? 2 : int'(cfg_div)) + int'(cfg_odd);
            h   = n / 2;
            cl  = slot_len();
            dl  = data_len();
            case (cfg_std)
                2'd0: off = 1;
                2'd1: off = 0;
                2'd2: off = cl - dl;
                default: off = cfg_pcm_long ? 0 : 1;
            endcase
            tag   = s_right;
            m_acc = s_valid && !m_full[tag];
            e++;
            m_bclk = ((e % n) >= h) ^ cfg_pol;
            m_mclk = cfg_mclk_en ? ~m_mclk : 1'b0;
            if (e % n == 0) begin
                pn  = (e / n - 1) % (2 * cl);
                rel = (pn - off + 2 * cl) % (2 * cl);
                ch  = rel / cl;
                k   = rel % cl;
                if (k == 0) begin
                    m_cur = m_full[ch] ? m_slot[ch] : 32'd0;
                    m_full[ch] = 0;
                end else begin
                    m_cur = m_cur << 1;
                end
                m_sd = (k < dl) ? m_cur[31] : 1'b0;
                if (cfg_std == 2'd3) m_ws = cfg_pcm_long ? (pn < 13) : (pn == 0);
                else                 m_ws = (pn >= cl) ^ cfg_wsinv;
            end
            if (m_acc) begin
                m_slot[tag] = aligned(s_data);
                m_full[tag] = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && live) begin
            check(bclk, m_bclk, "R2/R3 bclk");
            check(mclk, m_mclk, "R11 mclk");
            check(s_ready, !m_full[s_right], "R10 ready");
            if (cfg_std == 2'd3) begin
                check(ws, m_ws, "R7 ws");
                check(sd, m_sd, "R7/R8/R9/R10/R12 sd");
            end else if (cfg_std == 2'd0) begin
                check(ws, m_ws, "R4 ws");
                check(sd, m_sd, "R5/R8/R9/R10/R12 sd");
            end else begin
                check(ws, m_ws, "R4 ws");
                check(sd, m_sd, "R6/R8/R9/R10/R12 sd");
            end
        end
    end

    task automatic scenario(input bit [1:0] std, input bit pl, input bit [1:0] dlen,
                            input bit chl, input bit pol, input bit inv, input bit la,
                            input bit [7:0] div, input bit odd, input bit men,
                            input int feed, input int cycles);
        int sent;
        live  = 1'b0;
        @(negedge clk); #2;
        rst_n = 1'b0; s_valid = 1'b0; s_right = 1'b0;
        cfg_std = std; cfg_pcm_long = pl; cfg_dlen = dlen; cfg_chlen = chl;
        cfg_pol = pol; cfg_wsinv = inv; cfg_left_align = la; cfg_div = div;
        cfg_odd = odd; cfg_mclk_en = men;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bclk, 1'b0, "R1 bclk");
        check(ws, 1'b0, "R1 ws");
        check(sd, 1'b0, "R1 sd");
        check(mclk, 1'b0, "R1 mclk");
        check(s_ready, 1'b1, "R1 ready");
        #2;
        rst_n = 1'b1;
        live  = 1'b1;
        sent  = 0;
        lfsr  = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        s_data = lfsr;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #2;
            if (s_valid && m_acc) begin
                sent++;
                s_right = ~s_right;
                lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                s_data = lfsr;
            end
            s_valid = (sent < feed) && ((i % 5) != 2);
        end
        s_valid = 1'b0;
    endtask

    initial begin
        // std pl dlen chl pol inv la div odd men feed cycles
        scenario(2'd0, 0, 2'd0, 0, 0, 0, 0, 8'd2, 0, 1, 10, 1000);  // R5 Philips 16/16
        scenario(2'd0, 0, 2'd2, 1, 1, 1, 1, 8'd3, 1, 0,  8, 2200);  // R5 Philips 32/32 inverted
        scenario(2'd1, 0, 2'd1, 1, 1, 0, 1, 8'd3, 1, 1,  8, 2400);  // R6 MSB 24/32 left aligned
        scenario(2'd2, 0, 2'd1, 0, 0, 1, 0, 8'd2, 0, 0,  8, 1600);  // R6 R8 LSB 24 forced 32 slot
        scenario(2'd2, 0, 2'd0, 1, 0, 0, 1, 8'd2, 1, 1,  8, 1800);  // R6 LSB 16/32
        scenario(2'd3, 0, 2'd0, 0, 1, 0, 0, 8'd2, 0, 1, 10, 1000);  // R7 PCM short
        scenario(2'd3, 1, 2'd2, 0, 0, 0, 1, 8'd4, 0, 0,  8, 2600);  // R7 PCM long 32
        scenario(2'd1, 0, 2'd3, 0, 0, 0, 0, 8'd0, 1, 1,  6, 1800);  // R8 illegal length, R2 clamp
        scenario(2'd0, 0, 2'd0, 1, 0, 0, 0, 8'd1, 0, 1,  0,  600);  // R10 no samples: zeros
        live = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule